// File: doc/BRIEF.md
# Two-Segment Base-and-Limit Address Translator

This block maps logical addresses to physical ones for a pipeline that keeps two separate relocation windows. The instruction window covers instruction fetch. The data window covers loads and stores. Each window is described by a base and a limit.

A fetch address is relocated by adding the instruction base. A data address is the sum of a register operand, an immediate and the data base. That three-term sum uses one carry-save compression followed by a single carry-propagate adder, so relocation costs only a few gate levels more than the plain effective-address add. In parallel, each logical address is compared against its window's limit. The block raises a violation when the address lands at or beyond the limit.

All four window registers are reached through a small configuration port, which only works in supervisor mode. A user-mode write is dropped and reported with a one-cycle privilege-error pulse. The translated addresses and both violation flags are registered once, so each translation takes one clock.

Top module: `seg_xlate`

## Requirements
- R1: One cycle after inputs are presented, `fetch_pa` equals `pc` plus the instruction base, modulo 2^AW.
- R2: One cycle after inputs are presented, `data_pa` equals `rs_val + imm` plus the data base, modulo 2^AW.
- R3: `fetch_viol` is 1 exactly when `pc` is unsigned greater than or equal to the instruction limit. It is registered with the same one-cycle latency as R1.
- R4: `data_viol` is 1 exactly when the wrapped sum `rs_val + imm` (modulo 2^AW) is unsigned greater than or equal to the data limit. It is registered with the same one-cycle latency as R2.
- R5: `cfg_sel` picks a window register:
  - 0 is the instruction base.
  - 1 is the instruction limit.
  - 2 is the data base.
  - 3 is the data limit.

  A write with `cfg_we=1` and `sup_mode=1` updates the selected register at the clock edge. A translation presented in that same cycle still uses the value from before the write.
- R6: A write attempted with `sup_mode=0` leaves all four window registers unchanged.
- R7: `priv_err` is 1 for exactly the one cycle after an edge at which `cfg_we=1` and `sup_mode=0`. Otherwise it is 0.
- R8: `cfg_rdata` combinationally shows the register selected by `cfg_sel` while `sup_mode=1`. It shows zero while `sup_mode=0`.
- R9: Reset (`rst_n=0`) has these effects:
  - All four window registers clear to zero.
  - `fetch_pa` and `data_pa` become 0.
  - Both violation flags become 1.
  - `priv_err` becomes 0.

  Until a limit is programmed, every access on that window violates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_mode | input | 1 | 1 while the processor runs in supervisor mode |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window register select (0 ibase, 1 ilimit, 2 dbase, 3 dlimit) |
| cfg_wdata | input | AW | Write data |
| cfg_rdata | output | AW | Selected register, zero outside supervisor mode |
| priv_err | output | 1 | One-cycle pulse after a user-mode write attempt |
| pc | input | AW | Logical fetch address |
| rs_val | input | AW | Register operand of the data address |
| imm | input | AW | Immediate of the data address |
| fetch_pa | output | AW | Relocated fetch address |
| fetch_viol | output | 1 | Fetch address outside the instruction window |
| data_pa | output | AW | Relocated data address |
| data_viol | output | 1 | Data address outside the data window |

## Verification
Two things can happen in the same cycle: a window register write and a translation that reads the same register. The bench provokes this on purpose by writing a new base or limit while a fetch and a data access are presented. It expects the result at the next edge to reflect the old value, and the cycle after that to reflect the new one. The same collision is also driven with `sup_mode=0`. In that case the translation must be unaffected both then and afterwards, and `priv_err` must pulse. Randomized operands and writes mix these collisions among ordinary traffic. Directed cases sit exactly on and just below each limit, and on wrap-around of both the effective-address sum and the relocation sum.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int SEL_W = 2;
   localparam int NUM_WIN_REGS = 4;
   typedef enum logic [SEL_W-1:0] {
      SEL_IBASE  = 2'd0,
      SEL_ILIMIT = 2'd1,
      SEL_DBASE  = 2'd2,
      SEL_DLIMIT = 2'd3
   } win_sel_e;
endpackage

// File: rtl/seg_win_regs.sv
module seg_win_regs
   import seg_xlate_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sup_mode,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   output logic [AW-1:0]    cfg_rdata,
   output logic             priv_err,
   output logic [AW-1:0]    ibase,
   output logic [AW-1:0]    ilimit,
   output logic [AW-1:0]    dbase,
   output logic [AW-1:0]    dlimit
);
   logic [AW-1:0] regs_q [NUM_WIN_REGS];

   for (genvar g = 0; g < NUM_WIN_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[g] <= '0;
         end else if (cfg_we && sup_mode && (cfg_sel == SEL_W'(g))) begin
            regs_q[g] <= cfg_wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_err <= 1'b0;
      end else begin
         priv_err <= cfg_we && !sup_mode;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (sup_mode) begin
         cfg_rdata = regs_q[cfg_sel];
      end
   end

   assign ibase  = regs_q[SEL_IBASE];
   assign ilimit = regs_q[SEL_ILIMIT];
   assign dbase  = regs_q[SEL_DBASE];
   assign dlimit = regs_q[SEL_DLIMIT];
endmodule

// File: rtl/seg_add3.sv
module seg_add3 #(
   parameter int AW      = 32,
   parameter bit USE_CSA = 1'b1
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic [AW-1:0] c,
   output logic [AW-1:0] y
);
   if (USE_CSA) begin : g_csa
      logic [AW-1:0] sum_v;
      logic [AW-1:0] carry_v;
      assign sum_v   = a ^ b ^ c;
      assign carry_v = {((a[AW-2:0] & b[AW-2:0]) |
                         (a[AW-2:0] & c[AW-2:0]) |
                         (b[AW-2:0] & c[AW-2:0])), 1'b0};
      assign y = sum_v + carry_v;
   end else begin : g_chain
      logic [AW-1:0] part;
      assign part = a + b;
      assign y    = part + c;
   end
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] laddr,
   input  logic [AW-1:0] limit,
   output logic          outside
);
   assign outside = !(laddr < limit);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int AW      = 32,
   parameter bit USE_CSA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sup_mode,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [AW-1:0]    cfg_wdata,
   output logic [AW-1:0]    cfg_rdata,
   output logic             priv_err,
   input  logic [AW-1:0]    pc,
   input  logic [AW-1:0]    rs_val,
   input  logic [AW-1:0]    imm,
   output logic [AW-1:0]    fetch_pa,
   output logic             fetch_viol,
   output logic [AW-1:0]    data_pa,
   output logic             data_viol
);
   if (AW < 4 || AW > 64) begin : g_bad_aw
      $error("seg_xlate: AW must lie in 4..64");
   end

   logic [AW-1:0] ibase, ilimit, dbase, dlimit;
   logic [AW-1:0] fetch_pa_d, data_pa_d, data_la;
   logic          fetch_out_d, data_out_d;

   seg_win_regs #(.AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .priv_err(priv_err), .ibase(ibase), .ilimit(ilimit),
      .dbase(dbase), .dlimit(dlimit)
   );

   assign fetch_pa_d = pc + ibase;
   assign data_la    = rs_val + imm;

   seg_add3 #(.AW(AW), .USE_CSA(USE_CSA)) u_dsum (
      .a(rs_val), .b(imm), .c(dbase), .y(data_pa_d)
   );

   seg_limit_cmp #(.AW(AW)) u_icmp (
      .laddr(pc), .limit(ilimit), .outside(fetch_out_d)
   );

   seg_limit_cmp #(.AW(AW)) u_dcmp (
      .laddr(data_la), .limit(dlimit), .outside(data_out_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetch_pa   <= '0;
         data_pa    <= '0;
         fetch_viol <= 1'b1;
         data_viol  <= 1'b1;
      end else begin
         fetch_pa   <= fetch_pa_d;
         data_pa    <= data_pa_d;
         fetch_viol <= fetch_out_d;
         data_viol  <= data_out_d;
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sup_mode,
   input logic          cfg_we,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] rs_val,
   input logic [AW-1:0] imm,
   input logic [AW-1:0] fetch_pa,
   input logic          fetch_viol,
   input logic [AW-1:0] data_pa,
   input logic          data_viol,
   input logic          priv_err,
   input logic [AW-1:0] cfg_rdata,
   input logic [AW-1:0] ibase,
   input logic [AW-1:0] ilimit,
   input logic [AW-1:0] dbase,
   input logic [AW-1:0] dlimit
);
   logic          armed;
   logic [AW-1:0] ea, exp_ipa, exp_dpa;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign ea      = rs_val + imm;
   assign exp_ipa = pc + ibase;
   assign exp_dpa = ea + dbase;

   p_fetch_reloc_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      fetch_pa == $past(exp_ipa));
   p_data_reloc_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      data_pa == $past(exp_dpa));
   p_fetch_limit_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      fetch_viol == ($past(pc) >= $past(ilimit)));
   p_data_limit_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      data_viol == ($past(ea) >= $past(dlimit)));
   p_user_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !sup_mode) |=> ($stable(ibase) && $stable(ilimit) &&
                                 $stable(dbase) && $stable(dlimit)));
   p_priv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !sup_mode) |=> priv_err);
   p_priv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && !sup_mode) |=> !priv_err);
   p_rdata_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_mode |-> (cfg_rdata == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
   .pc(pc), .rs_val(rs_val), .imm(imm),
   .fetch_pa(fetch_pa), .fetch_viol(fetch_viol),
   .data_pa(data_pa), .data_viol(data_viol),
   .priv_err(priv_err), .cfg_rdata(cfg_rdata),
   .ibase(ibase), .ilimit(ilimit), .dbase(dbase), .dlimit(dlimit)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sup_mode = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [AW-1:0] cfg_rdata;
   logic          priv_err;
   logic [AW-1:0] pc = '0, rs_val = '0, imm = '0;
   logic [AW-1:0] fetch_pa, data_pa;
   logic          fetch_viol, data_viol;

   int checks = 0;
   int errors = 0;
   logic [AW-1:0] mdl [4];

   always #5 clk = ~clk;

   seg_xlate #(.AW(AW)) u_seg_xlate (
      .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .priv_err(priv_err), .pc(pc), .rs_val(rs_val), .imm(imm),
      .fetch_pa(fetch_pa), .fetch_viol(fetch_viol),
      .data_pa(data_pa), .data_viol(data_viol)
   );

   task automatic check(input string req, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] f_ipa(input logic [AW-1:0] p);
      return p + mdl[0];
   endfunction
   function automatic logic [AW-1:0] f_dpa(input logic [AW-1:0] r, input logic [AW-1:0] i);
      return r + i + mdl[2];
   endfunction
   function automatic logic f_iv(input logic [AW-1:0] p);
      return p >= mdl[1];
   endfunction
   function automatic logic f_dv(input logic [AW-1:0] r, input logic [AW-1:0] i);
      logic [AW-1:0] e;
      e = r + i;
      return e >= mdl[3];
   endfunction

   // Drive at negedge, let one edge pass, check at the following negedge.
   task automatic step(input logic sup, input logic we, input logic [1:0] sel,
                       input logic [AW-1:0] wd, input logic [AW-1:0] p,
                       input logic [AW-1:0] r, input logic [AW-1:0] i);
      logic [AW-1:0] e_ipa, e_dpa;
      logic e_iv, e_dv, e_pe;
      sup_mode = sup; cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
      pc = p; rs_val = r; imm = i;
      e_ipa = f_ipa(p); e_dpa = f_dpa(r, i);
      e_iv = f_iv(p); e_dv = f_dv(r, i);
      e_pe = we && !sup;
      @(posedge clk);
      if (we && sup) mdl[sel] = wd;
      @(negedge clk);
      check("R1 fetch_pa", fetch_pa, e_ipa);
      check("R2 data_pa", data_pa, e_dpa);
      check("R3 fetch_viol", AW'(fetch_viol), AW'(e_iv));
      check("R4 data_viol", AW'(data_viol), AW'(e_dv));
      check("R7 priv_err", AW'(priv_err), AW'(e_pe));
      cfg_we = 1'b0;
   endtask

   task automatic prog(input logic [1:0] sel, input logic [AW-1:0] v);
      step(1'b1, 1'b1, sel, v, '0, '0, '0);
   endtask

   task automatic readback(input string req, input logic sup);
      for (int k = 0; k < 4; k++) begin
         sup_mode = sup; cfg_sel = 2'(k); cfg_we = 1'b0;
         #1;
         check(req, cfg_rdata, sup ? mdl[k] : '0);
      end
   endtask

   initial begin
      for (int k = 0; k < 4; k++) mdl[k] = '0;
      void'($urandom(32'd2468));
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 fetch_pa reset", fetch_pa, '0);
      check("R9 data_pa reset", data_pa, '0);
      check("R9 fetch_viol reset", AW'(fetch_viol), 1);
      check("R9 data_viol reset", AW'(data_viol), 1);
      check("R9 priv_err reset", AW'(priv_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      readback("R9 regs zero after reset", 1'b1);
      // R9: unprogrammed limits make every access violate
      step(1'b0, 1'b0, 2'd0, '0, 32'h0, 32'h0, 32'h0);
      step(1'b0, 1'b0, 2'd0, '0, 32'h1234, 32'h10, 32'h20);

      // R5: program each register by encoding, R8 readback
      prog(2'd0, 32'h0010_0000);
      prog(2'd1, 32'h0000_4000);
      prog(2'd2, 32'h0080_0000);
      prog(2'd3, 32'h0000_2000);
      readback("R8 supervisor readback", 1'b1);
      readback("R8 user readback zero", 1'b0);

      // R3/R4 limit boundaries
      step(1'b0, 1'b0, 2'd0, '0, 32'h0000_3FFF, 32'h0000_1000, 32'h0000_0FFF);
      step(1'b0, 1'b0, 2'd0, '0, 32'h0000_4000, 32'h0000_1000, 32'h0000_1000);
      // R4 wrap of rs+imm: negative immediate
      step(1'b0, 1'b0, 2'd0, '0, 32'h0, 32'h0000_0010, 32'hFFFF_FFF0);
      step(1'b0, 1'b0, 2'd0, '0, 32'h0, 32'h0000_0010, 32'hFFFF_FFE0);
      // R1/R2 wrap of relocation sum
      prog(2'd2, 32'hFFFF_FF00);
      prog(2'd0, 32'hFFFF_FFF0);
      step(1'b0, 1'b0, 2'd0, '0, 32'h0000_0100, 32'h0000_0200, 32'h0000_0001);

      // R5: same-cycle write and translation uses old value
      step(1'b1, 1'b1, 2'd0, 32'h0000_5000, 32'h0000_0040, 32'h8, 32'h8);
      step(1'b1, 1'b0, 2'd0, '0, 32'h0000_0040, 32'h8, 32'h8);
      step(1'b1, 1'b1, 2'd3, 32'h0000_0010, 32'h0, 32'h8, 32'h8);
      step(1'b1, 1'b0, 2'd0, '0, 32'h0, 32'h8, 32'h8);

      // R6/R7: user-mode write dropped and flagged
      step(1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0000_3000, 32'h4, 32'h4);
      step(1'b0, 1'b1, 2'd2, 32'h1111_1111, 32'h0000_3000, 32'h4, 32'h4);
      step(1'b0, 1'b0, 2'd0, '0, 32'h0000_3000, 32'h4, 32'h4);
      readback("R6 regs unchanged after user write", 1'b1);

      // Random traffic with mixed writes
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] p, r, i, wd;
         logic sup, we;
         logic [1:0] sel;
         p = $urandom; r = $urandom; i = $urandom; wd = $urandom;
         if ($urandom_range(1, 0) == 1) begin
            p = p & 32'h0000_FFFF; r = r & 32'h0000_FFFF; i = i & 32'h0000_FFFF;
         end
         if ((wd[0] == 1'b1) && (wd[1] == 1'b1)) wd = wd & 32'h0001_FFFF;
         sup = ($urandom_range(3, 0) != 0);
         we  = ($urandom_range(3, 0) == 0);
         sel = 2'($urandom_range(3, 0));
         step(sup, we, sel, wd, p, r, i);
      end
      readback("R8 final readback", 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule